// File: doc/BRIEF.md
# Monitor Configuration Register with Interrupt Pin Control

This block holds the 16-bit configuration word of a monitoring converter and drives its one multipurpose interrupt pin. A plain register port writes the word and reads it back. The word carries the autocycle enable, the input-mode and reference-range selections, the active-low enables for delayed sampling, delayed bit trials and the bus glitch filters, and a field that sets what the interrupt pin does.

A two-bit pin-function field picks one of three pin behaviours: no interrupt, a busy indication that follows a conversion-in-progress input, or an alert indication that follows an "any alert pending" input. A polarity bit sets which level counts as asserted.

The fourth code of the field is a clear command. It does three things:
- It raises a one-cycle `alert_clear` strobe, which the alert-status and result logic elsewhere use to drop their pending alerts.
- It deasserts the pin for that cycle.
- It is stored as alert mode, so the field never reads back as the clear code.

Top module: `monitor_cfg_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x0000, `alert_clear` is 0 and `irq_pin` is 1. That is the deasserted level for the active-low polarity that reset selects.
- R2: A write (`wr_en` high at a rising edge) appears on `rd_data` from that edge on. The bits that are not reserved and are not a clear code read back exactly as written.
- R3: Bit 15 is reserved. It always reads 0, and writing 1 to it has no effect.
- R4: Writing 11 to bits [2:1] stores 10 (alert mode) there. Every other bit of that write is stored as written.
- R5: A write whose bits [2:1] are 11 drives `alert_clear` high for exactly the one cycle that follows the write edge. A write with any other code in bits [2:1] leaves `alert_clear` low.
- R6: Bits [2:1] = 01 select busy mode. In this mode the pin is at the asserted level exactly while `conv_busy` is 1.
- R7: Bits [2:1] = 10 select alert mode. In this mode the pin is at the asserted level exactly while `alert_any` is 1. The exception is the cycle in which `alert_clear` is high: the pin is then deasserted.
- R8: Bits [2:1] = 00 select no-interrupt mode. In this mode the pin stays deasserted whatever `conv_busy` and `alert_any` do.
- R9: Bit 0 sets the polarity. The asserted pin level equals bit 0 (1 = active high), and the deasserted level is its inverse.
- R10: The decoded outputs follow the stored word as follows:
  - `cfg_autocycle` = bit 12.
  - `cfg_smp_dly_en` = NOT bit 14.
  - `cfg_trial_dly_en` = NOT bit 13.
  - `cfg_filt_en` = NOT bit 3.
  - `cfg_in_mode` = bits [11:8].
  - `cfg_ref_rng` = bits [7:4].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Stored configuration word |
| conv_busy | input | 1 | High while a conversion is in progress |
| alert_any | input | 1 | High while any alert status bit is set |
| alert_clear | output | 1 | One-cycle strobe that clears pending alerts |
| irq_pin | output | 1 | Interrupt pin level, polarity applied |
| cfg_autocycle | output | 1 | Autocycle mode enabled |
| cfg_smp_dly_en | output | 1 | Delayed sampling enabled |
| cfg_trial_dly_en | output | 1 | Delayed bit trials enabled |
| cfg_filt_en | output | 1 | Bus glitch filters enabled |
| cfg_in_mode | output | 4 | Differential and pseudo-differential pair selections |
| cfg_ref_rng | output | 4 | Per-channel double reference range selections |

## Verification
The pin assertions assume that `conv_busy` and `alert_any` are clean synchronous levels that change only between clock edges. The bench therefore drives them, together with `wr_en` and `wr_data`, only on falling edges. The assertions also assume that whatever drives `alert_any` may keep it high through the clear strobe cycle. The bench deliberately holds `alert_any` high across a clear, so the forced deassertion and the return of the pin one cycle later are both visible. Reset is held from time zero so that no property sees undriven state.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

    localparam int CFG_W   = 16;
    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        PIN_NONE  = 2'b00,
        PIN_BUSY  = 2'b01,
        PIN_ALERT = 2'b10,
        PIN_CLEAR = 2'b11
    } pin_fn_e;

    // Bit positions are fixed by the decoding logic that consumes them.
    typedef struct packed {
        logic                rsvd;        // 15
        logic                smp_dly_n;   // 14, active-low enable
        logic                trial_dly_n; // 13, active-low enable
        logic                autocycle;   // 12
        logic [FIELD_W-1:0]  in_mode;     // 11:8
        logic [FIELD_W-1:0]  ref_rng;     // 7:4
        logic                filt_n;      // 3, active-low enable
        pin_fn_e             pin_fn;      // 2:1
        logic                pol_hi;      // 0
    } cfg_t;

    function automatic logic is_clear_code(input logic [CFG_W-1:0] w);
        return w[2:1] == PIN_CLEAR;
    endfunction

    // Value actually stored for a written word.
    function automatic cfg_t store_value(input logic [CFG_W-1:0] w);
        cfg_t c;
        c = cfg_t'(w);
        c.rsvd = 1'b0;
        if (c.pin_fn == PIN_CLEAR)
            c.pin_fn = PIN_ALERT;
        return c;
    endfunction

endpackage

// File: rtl/mcfg_store.sv
module mcfg_store
    import mcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_q,
    output logic             clr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (wr_en) begin
                cfg_q <= store_value(wr_data);
                clr_q <= is_clear_code(wr_data);
            end
        end
    end

endmodule

// File: rtl/mcfg_pin.sv
module mcfg_pin
    import mcfg_pkg::*;
(
    input  pin_fn_e pin_fn,
    input  logic    pol_hi,
    input  logic    conv_busy,
    input  logic    alert_any,
    input  logic    clr,
    output logic    pin
);

    logic active;

    always_comb begin
        unique case (pin_fn)
            PIN_BUSY:  active = conv_busy;
            PIN_ALERT: active = alert_any;
            default:   active = 1'b0;
        endcase
        if (clr)
            active = 1'b0;
    end

    assign pin = active ^ ~pol_hi;

endmodule

// File: rtl/monitor_cfg_ctrl.sv
module monitor_cfg_ctrl
    import mcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W-1:0]   rd_data,
    input  logic               conv_busy,
    input  logic               alert_any,
    output logic               alert_clear,
    output logic               irq_pin,
    output logic               cfg_autocycle,
    output logic               cfg_smp_dly_en,
    output logic               cfg_trial_dly_en,
    output logic               cfg_filt_en,
    output logic [FIELD_W-1:0] cfg_in_mode,
    output logic [FIELD_W-1:0] cfg_ref_rng
);

    cfg_t cfg;
    logic clr;

    mcfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg),
        .clr_q   (clr)
    );

    mcfg_pin u_pin (
        .pin_fn    (cfg.pin_fn),
        .pol_hi    (cfg.pol_hi),
        .conv_busy (conv_busy),
        .alert_any (alert_any),
        .clr       (clr),
        .pin       (irq_pin)
    );

    assign rd_data          = cfg;
    assign alert_clear      = clr;
    assign cfg_autocycle    = cfg.autocycle;
    assign cfg_smp_dly_en   = ~cfg.smp_dly_n;
    assign cfg_trial_dly_en = ~cfg.trial_dly_n;
    assign cfg_filt_en      = ~cfg.filt_n;
    assign cfg_in_mode      = cfg.in_mode;
    assign cfg_ref_rng      = cfg.ref_rng;

endmodule

// File: rtl/monitor_cfg_chk.sv
module monitor_cfg_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        conv_busy,
    input logic        alert_any,
    input logic        alert_clear,
    input logic        irq_pin,
    input logic        cfg_autocycle,
    input logic        cfg_filt_en
);

    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[15] == 1'b0);

    a_r4_no_clear_readback: assert property (@(posedge clk) disable iff (rst)
        rd_data[2:1] != 2'b11);

    a_r5_pulse_source: assert property (@(posedge clk) disable iff (rst)
        alert_clear |-> $past(wr_en) && $past(wr_data[2:1]) == 2'b11);

    a_r5_pulse_stored_alert: assert property (@(posedge clk) disable iff (rst)
        alert_clear |-> rd_data[2:1] == 2'b10);

    a_r6_busy_pin: assert property (@(posedge clk) disable iff (rst)
        rd_data[2:1] == 2'b01 |-> irq_pin == (conv_busy ? rd_data[0] : ~rd_data[0]));

    a_r7_alert_pin: assert property (@(posedge clk) disable iff (rst)
        (rd_data[2:1] == 2'b10 && !alert_clear)
            |-> irq_pin == (alert_any ? rd_data[0] : ~rd_data[0]));

    a_r7_clear_deasserts: assert property (@(posedge clk) disable iff (rst)
        alert_clear |-> irq_pin == ~rd_data[0]);

    a_r8_none_idle: assert property (@(posedge clk) disable iff (rst)
        rd_data[2:1] == 2'b00 |-> irq_pin == ~rd_data[0]);

    a_r10_fields: assert property (@(posedge clk) disable iff (rst)
        cfg_autocycle == rd_data[12] && cfg_filt_en == ~rd_data[3]);

endmodule

bind monitor_cfg_ctrl monitor_cfg_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .conv_busy     (conv_busy),
    .alert_any     (alert_any),
    .alert_clear   (alert_clear),
    .irq_pin       (irq_pin),
    .cfg_autocycle (cfg_autocycle),
    .cfg_filt_en   (cfg_filt_en)
);

// File: tb/monitor_cfg_ctrl_bench.sv
module monitor_cfg_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        conv_busy = 1'b0;
    logic        alert_any = 1'b0;
    logic        alert_clear;
    logic        irq_pin;
    logic        cfg_autocycle, cfg_smp_dly_en, cfg_trial_dly_en, cfg_filt_en;
    logic [3:0]  cfg_in_mode, cfg_ref_rng;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    monitor_cfg_ctrl u_monitor_cfg_ctrl (
        .clk              (clk),
        .rst              (rst),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .rd_data          (rd_data),
        .conv_busy        (conv_busy),
        .alert_any        (alert_any),
        .alert_clear      (alert_clear),
        .irq_pin          (irq_pin),
        .cfg_autocycle    (cfg_autocycle),
        .cfg_smp_dly_en   (cfg_smp_dly_en),
        .cfg_trial_dly_en (cfg_trial_dly_en),
        .cfg_filt_en      (cfg_filt_en),
        .cfg_in_mode      (cfg_in_mode),
        .cfg_ref_rng      (cfg_ref_rng)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Drive a write on a falling edge; return at the next falling edge,
    // when the stored value and any strobe are visible.
    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 alert_clear", {15'd0, alert_clear}, 16'd0);
        chk("R1 irq_pin", {15'd0, irq_pin}, 16'd1);
    endtask

    task automatic t_readwrite;
        wr(16'h5A34);
        chk("R2 readback", rd_data, 16'h5A34);
        chk("R5 no pulse on 10", {15'd0, alert_clear}, 16'd0);
        chk("R10 autocycle", {15'd0, cfg_autocycle}, 16'd1);
        chk("R10 smp_dly_en", {15'd0, cfg_smp_dly_en}, 16'd0);
        chk("R10 trial_dly_en", {15'd0, cfg_trial_dly_en}, 16'd1);
        chk("R10 filt_en", {15'd0, cfg_filt_en}, 16'd1);
        chk("R10 in_mode", {12'd0, cfg_in_mode}, 16'h000A);
        chk("R10 ref_rng", {12'd0, cfg_ref_rng}, 16'h0003);
        wr(16'hA5C2);
        chk("R3 reserved dropped", rd_data, 16'h25C2);
        chk("R5 no pulse on 01", {15'd0, alert_clear}, 16'd0);
    endtask

    task automatic t_clear_code;
        wr(16'hFFFF);
        chk("R4 clear stored as alert", rd_data, 16'h7FFD);
        chk("R5 pulse high", {15'd0, alert_clear}, 16'd1);
        @(negedge clk);
        chk("R5 pulse one cycle", {15'd0, alert_clear}, 16'd0);
    endtask

    task automatic t_busy;
        wr(16'h0003);
        conv_busy = 1'b1; #1;
        chk("R6 busy high asserted", {15'd0, irq_pin}, 16'd1);
        conv_busy = 1'b0; #1;
        chk("R6 busy low deasserted", {15'd0, irq_pin}, 16'd0);
        wr(16'h0002);
        conv_busy = 1'b1; #1;
        chk("R9 busy active low", {15'd0, irq_pin}, 16'd0);
        conv_busy = 1'b0; #1;
        chk("R9 idle level active low", {15'd0, irq_pin}, 16'd1);
    endtask

    task automatic t_none;
        wr(16'h0001);
        conv_busy = 1'b1; alert_any = 1'b1; #1;
        chk("R8 none, active high", {15'd0, irq_pin}, 16'd0);
        wr(16'h0000);
        chk("R8 none, active low", {15'd0, irq_pin}, 16'd1);
        conv_busy = 1'b0; alert_any = 1'b0;
    endtask

    task automatic t_alert;
        wr(16'h0005);
        alert_any = 1'b1; #1;
        chk("R7 alert asserted", {15'd0, irq_pin}, 16'd1);
        wr(16'h0007);
        chk("R4 clear readback", rd_data, 16'h0005);
        chk("R5 strobe on clear", {15'd0, alert_clear}, 16'd1);
        chk("R7 pin deasserted in clear cycle", {15'd0, irq_pin}, 16'd0);
        @(negedge clk);
        chk("R7 pin follows alert again", {15'd0, irq_pin}, 16'd1);
        alert_any = 1'b0; #1;
        chk("R7 alert gone", {15'd0, irq_pin}, 16'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readwrite();
        t_clear_code();
        t_busy();
        t_none();
        t_alert();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule